// File: doc/BRIEF.md
# Clock Generation Control Register File

This block is the software-visible configuration store of a clock generation unit. It holds one control word for each of five integer dividers and for each of twenty-eight output clock slots. From these words it drives the source select, the divide value and the gate enable wires that the clock fabric uses. The muxes, dividers and oscillators themselves live elsewhere. A simple 32-bit read/write bus reaches the registers. Software writes a word and reads it back one cycle after a read strobe.

Every register accepts only the source codes its own slot can use. A write that names a source outside that set keeps the old selection and raises a sticky error flag. The other fields of that write still take effect. The safe output is locked to the internal RC source and cannot be gated. The USB output accepts only the USB PLL. Four output slots are reserved and stay inert. Each divider and each output also reports an effective-enabled status. That status is true only when its own gate is open and the source it selects is also running. The status follows chains such as a divider fed by divider A.

Top module: `clkgen_ctrl_regs`

## Requirements
- R1: Divider i (0..4, called A..E) has its word at byte address 0x48+4*i. Bit 0 is power-down (1 = gated off). The divide value sits at bit 2 with width 2 for A, 8 for E and 4 for the others. The source select sits at bits 28:24. All other bits read 0. The div_sel, div_val (zero-extended to 8 bits) and div_on (= not power-down) ports show the stored fields.
- R2: bus_rdata holds the addressed word from the clock edge that samples bus_rd. Addresses that map no register read as 0.
- R3: Divider A accepts source codes 0-4 and 6-9 only.
- R4: Dividers B..E accept source codes 0-4, 6, 8, 9 and 12 only.
- R5: Output j has its word at 0x5C+4*j, with power-down at bit 0 and select at bits 28:24. Output 1 accepts only code 7. Outputs 3, 20, 26 and 27 accept codes 0-4, 6-9 and 12-16. The other outputs (2, 4..19, 25) accept codes 0-4, 6, 8, 9 and 12-16.
- R6: A write whose select code is not accepted by that register leaves the select unchanged, still updates power-down and divide value, and sets sel_err. sel_err stays set until reset.
- R7: Output 0 always reads select 1 with power-down 0. It keeps out_on[0] high. Writes to it change nothing and raise no error.
- R8: Output slots 21..24 read as 0, ignore writes, raise no error, and drive 0 on their out_sel, out_on and out_eff bits.
- R9: Source codes 0..11 are running when src_on[code] is 1. Codes 12..16 are running when divider code-12 is effectively enabled. div_eff and out_eff are 1 when the register is not powered down and its selected source is running. They are registered and reflect state one cycle later.
- R10: After reset, dividers read power-down 1, select 1 and value 0. Outputs 2..20 and 25..27 read power-down 1 and select 1. Output 1 reads power-down 1 and select 7. sel_err is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| src_on | input | 12 | Running flags for source codes 0..11 |
| div_sel | output | 25 | Divider selects, 5 bits each |
| div_val | output | 40 | Divider values, 8 bits each, zero-extended |
| div_on | output | 5 | Divider gate enables |
| div_eff | output | 5 | Divider effective-enabled status |
| out_sel | output | 140 | Output selects, 5 bits each |
| out_on | output | 28 | Output gate enables |
| out_eff | output | 28 | Output effective-enabled status |
| sel_err | output | 1 | Sticky illegal-select flag |

## Verification
The bench goes after the per-slot legality tables. Codes 5, 10, 11 and 17..31 are sent to each table, and so are the codes that differ between tables: 7 and 12..16 on dividers, and 7 on the common outputs. A wrong table would either store a forbidden source or refuse a valid one. Both show up in the readback and in sel_err. Refused writes must still update power-down and the divide value. Writes to the safe output and the reserved slots must not change state or set the error. The source chain is tested by turning divider A off while divider B and an output depend on it. A design that looked only at the local gate would keep reporting them as enabled.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
  localparam int SEL_W     = 5;
  localparam int SEL_LSB   = 24;
  localparam int VAL_LSB   = 2;
  localparam int VAL_MAX_W = 8;
  localparam int NUM_DIV   = 5;
  localparam int NUM_OUT   = 28;
  localparam int RSV_LO    = 21;
  localparam int RSV_HI    = 24;
  localparam int N_EXT     = 12;
  localparam int N_CODES   = N_EXT + NUM_DIV;

  typedef enum logic [2:0] {
    K_DIVA, K_DIVX, K_SAFE, K_USB, K_COMMON, K_ALL, K_RSVD
  } reg_kind_e;

  // bit n set: source code n may be selected
  function automatic logic [N_CODES-1:0] legal_mask(reg_kind_e k);
    case (k)
      K_DIVA:   return 17'h003DF;
      K_DIVX:   return 17'h0135F;
      K_SAFE:   return 17'h00002;
      K_USB:    return 17'h00080;
      K_COMMON: return 17'h1F35F;
      K_ALL:    return 17'h1F3DF;
      default:  return '0;
    endcase
  endfunction

  function automatic logic code_ok(reg_kind_e k, logic [SEL_W-1:0] c);
    logic [N_CODES-1:0] m;
    m = legal_mask(k);
    return (int'(c) < N_CODES) && m[c];
  endfunction

  function automatic reg_kind_e out_kind(int j);
    if (j == 0) return K_SAFE;
    if (j == 1) return K_USB;
    if (j >= RSV_LO && j <= RSV_HI) return K_RSVD;
    if (j == 3 || j == 20 || j == 26 || j == 27) return K_ALL;
    return K_COMMON;
  endfunction

  function automatic int div_width(int i);
    if (i == 0) return 2;
    if (i == NUM_DIV - 1) return 8;
    return 4;
  endfunction

  function automatic logic [SEL_W-1:0] reset_sel(reg_kind_e k);
    return (k == K_USB) ? SEL_W'(7) : SEL_W'(1);
  endfunction
endpackage

// File: rtl/clkgen_div_reg.sv
module clkgen_div_reg
  import clkgen_pkg::*;
#(
  parameter int        DATA_W = 32,
  parameter int        VAL_W  = 4,
  parameter reg_kind_e KIND   = K_DIVX
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic              pd_q,
  output logic [SEL_W-1:0]  sel_q,
  output logic [VAL_W-1:0]  val_q,
  output logic [DATA_W-1:0] rd_word,
  output logic              bad
);
  logic [SEL_W-1:0] sel_in;
  logic             ok;

  assign sel_in = wdata[SEL_LSB +: SEL_W];
  assign ok     = code_ok(KIND, sel_in);
  assign bad    = we && !ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      pd_q  <= 1'b1;
      sel_q <= reset_sel(KIND);
      val_q <= '0;
    end else if (we) begin
      pd_q  <= wdata[0];
      val_q <= wdata[VAL_LSB +: VAL_W];
      if (ok) sel_q <= sel_in;
    end
  end

  always_comb begin
    rd_word                   = '0;
    rd_word[0]                = pd_q;
    rd_word[VAL_LSB +: VAL_W] = val_q;
    rd_word[SEL_LSB +: SEL_W] = sel_q;
  end
endmodule

// File: rtl/clkgen_out_reg.sv
module clkgen_out_reg
  import clkgen_pkg::*;
#(
  parameter int        DATA_W = 32,
  parameter reg_kind_e KIND   = K_COMMON
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic              pd_q,
  output logic [SEL_W-1:0]  sel_q,
  output logic [DATA_W-1:0] rd_word,
  output logic              bad
);
  if (KIND == K_SAFE) begin : g_fixed
    assign pd_q  = 1'b0;
    assign sel_q = reset_sel(KIND);
    assign bad   = 1'b0;
    always_comb begin
      rd_word                   = '0;
      rd_word[SEL_LSB +: SEL_W] = sel_q;
    end
  end else if (KIND == K_RSVD) begin : g_hole
    assign pd_q    = 1'b1;
    assign sel_q   = '0;
    assign bad     = 1'b0;
    assign rd_word = '0;
  end else begin : g_live
    logic [SEL_W-1:0] sel_in;
    logic             ok;
    assign sel_in = wdata[SEL_LSB +: SEL_W];
    assign ok     = code_ok(KIND, sel_in);
    assign bad    = we && !ok;

    always_ff @(posedge clk) begin
      if (rst) begin
        pd_q  <= 1'b1;
        sel_q <= reset_sel(KIND);
      end else if (we) begin
        pd_q <= wdata[0];
        if (ok) sel_q <= sel_in;
      end
    end

    always_comb begin
      rd_word                   = '0;
      rd_word[0]                = pd_q;
      rd_word[SEL_LSB +: SEL_W] = sel_q;
    end
  end
endmodule

// File: rtl/clkgen_src_resolve.sv
module clkgen_src_resolve
  import clkgen_pkg::*;
#(
  parameter int PASSES = 2
) (
  input  logic [N_EXT-1:0]         src_on,
  input  logic [NUM_DIV-1:0]       div_pd,
  input  logic [NUM_DIV*SEL_W-1:0] div_sel,
  input  logic [NUM_OUT-1:0]       out_pd,
  input  logic [NUM_OUT*SEL_W-1:0] out_sel,
  output logic [NUM_DIV-1:0]       div_live,
  output logic [NUM_OUT-1:0]       out_live
);
  logic [N_CODES-1:0] code_live;

  always_comb begin
    code_live              = '0;
    code_live[N_EXT-1:0]   = src_on;
    div_live               = '0;
    // divider-to-divider chains settle after PASSES sweeps
    for (int p = 0; p < PASSES; p++) begin
      for (int i = 0; i < NUM_DIV; i++) begin
        div_live[i] = !div_pd[i] &&
                      (int'(div_sel[i*SEL_W +: SEL_W]) < N_CODES) &&
                      code_live[div_sel[i*SEL_W +: SEL_W]];
      end
      code_live[N_EXT +: NUM_DIV] = div_live;
    end
    for (int j = 0; j < NUM_OUT; j++) begin
      out_live[j] = !out_pd[j] &&
                    (int'(out_sel[j*SEL_W +: SEL_W]) < N_CODES) &&
                    code_live[out_sel[j*SEL_W +: SEL_W]];
    end
  end
endmodule

// File: rtl/clkgen_ctrl_regs.sv
module clkgen_ctrl_regs
  import clkgen_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int DIV_BASE = 'h48,
  parameter int OUT_BASE = 'h5C
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  input  logic [N_EXT-1:0]         src_on,
  output logic [NUM_DIV*SEL_W-1:0] div_sel,
  output logic [NUM_DIV*VAL_MAX_W-1:0] div_val,
  output logic [NUM_DIV-1:0]       div_on,
  output logic [NUM_DIV-1:0]       div_eff,
  output logic [NUM_OUT*SEL_W-1:0] out_sel,
  output logic [NUM_OUT-1:0]       out_on,
  output logic [NUM_OUT-1:0]       out_eff,
  output logic                     sel_err
);
  localparam int STRIDE = 4;

  logic [NUM_DIV-1:0]             d_pd, d_bad;
  logic [NUM_DIV-1:0][DATA_W-1:0] d_word;
  logic [NUM_OUT-1:0]             o_pd, o_bad;
  logic [NUM_OUT-1:0][DATA_W-1:0] o_word;
  logic [DATA_W-1:0]              rd_next;
  logic [NUM_DIV-1:0]             d_live;
  logic [NUM_OUT-1:0]             o_live;

  for (genvar i = 0; i < NUM_DIV; i++) begin : g_div
    localparam int        W    = div_width(i);
    localparam reg_kind_e KIND = (i == 0) ? K_DIVA : K_DIVX;
    logic         we;
    logic [W-1:0] val;
    assign we = bus_wr && (bus_addr == ADDR_W'(DIV_BASE + STRIDE*i));
    clkgen_div_reg #(.DATA_W(DATA_W), .VAL_W(W), .KIND(KIND)) u_reg (
      .clk(clk), .rst(rst), .we(we), .wdata(bus_wdata),
      .pd_q(d_pd[i]), .sel_q(div_sel[i*SEL_W +: SEL_W]), .val_q(val),
      .rd_word(d_word[i]), .bad(d_bad[i])
    );
    assign div_val[i*VAL_MAX_W +: VAL_MAX_W] = VAL_MAX_W'(val);
    assign div_on[i] = ~d_pd[i];
  end

  for (genvar j = 0; j < NUM_OUT; j++) begin : g_out
    logic we;
    assign we = bus_wr && (bus_addr == ADDR_W'(OUT_BASE + STRIDE*j));
    clkgen_out_reg #(.DATA_W(DATA_W), .KIND(out_kind(j))) u_reg (
      .clk(clk), .rst(rst), .we(we), .wdata(bus_wdata),
      .pd_q(o_pd[j]), .sel_q(out_sel[j*SEL_W +: SEL_W]),
      .rd_word(o_word[j]), .bad(o_bad[j])
    );
    assign out_on[j] = ~o_pd[j];
  end

  clkgen_src_resolve #(.PASSES(2)) u_resolve (
    .src_on(src_on), .div_pd(d_pd), .div_sel(div_sel),
    .out_pd(o_pd), .out_sel(out_sel),
    .div_live(d_live), .out_live(o_live)
  );

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NUM_DIV; i++)
      if (bus_addr == ADDR_W'(DIV_BASE + STRIDE*i)) rd_next = d_word[i];
    for (int j = 0; j < NUM_OUT; j++)
      if (bus_addr == ADDR_W'(OUT_BASE + STRIDE*j)) rd_next = o_word[j];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      sel_err   <= 1'b0;
      div_eff   <= '0;
      out_eff   <= '0;
    end else begin
      if (bus_rd) bus_rdata <= rd_next;
      if (|d_bad || |o_bad) sel_err <= 1'b1;
      div_eff <= d_live;
      out_eff <= o_live;
    end
  end
endmodule

// File: rtl/clkgen_ctrl_regs_chk.sv
module clkgen_ctrl_regs_chk
  import clkgen_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int DIV_BASE = 'h48
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     bus_wr,
  input logic                     bus_rd,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic [DATA_W-1:0]        bus_wdata,
  input logic [DATA_W-1:0]        bus_rdata,
  input logic [NUM_DIV*SEL_W-1:0] div_sel,
  input logic [NUM_DIV-1:0]       div_on,
  input logic [NUM_DIV-1:0]       div_eff,
  input logic [NUM_OUT*SEL_W-1:0] out_sel,
  input logic [NUM_OUT-1:0]       out_on,
  input logic [NUM_OUT-1:0]       out_eff,
  input logic                     sel_err
);
  logic a_bad;
  assign a_bad = bus_wr && (bus_addr == ADDR_W'(DIV_BASE)) &&
                 !code_ok(K_DIVA, bus_wdata[SEL_LSB +: SEL_W]);

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    sel_err |=> sel_err);

  // R3
  diva_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    a_bad |=> ($stable(div_sel[SEL_W-1:0]) && sel_err));

  // R7
  safe_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    out_on[0] && (out_sel[SEL_W-1:0] == SEL_W'(1)));

  // R5
  usb_only_chk: assert property (@(posedge clk) disable iff (rst)
    out_sel[SEL_W +: SEL_W] == SEL_W'(7));

  // R2
  hole_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'('hFC)) |=> (bus_rdata == '0));

  for (genvar i = 0; i < NUM_DIV; i++) begin : g_dchk
    // R9
    div_gate_chk: assert property (@(posedge clk) disable iff (rst)
      !div_on[i] |=> !div_eff[i]);
  end

  for (genvar j = 0; j < NUM_OUT; j++) begin : g_ochk
    // R9
    out_gate_chk: assert property (@(posedge clk) disable iff (rst)
      !out_on[j] |=> !out_eff[j]);
  end
endmodule

bind clkgen_ctrl_regs clkgen_ctrl_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_BASE(DIV_BASE)
) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .div_sel(div_sel),
  .div_on(div_on), .div_eff(div_eff), .out_sel(out_sel), .out_on(out_on),
  .out_eff(out_eff), .sel_err(sel_err)
);

// File: tb/sim_clkgen_ctrl_regs.sv
module sim_clkgen_ctrl_regs;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [11:0]  src_on = '0;
  logic [24:0]  div_sel;
  logic [39:0]  div_val;
  logic [4:0]   div_on, div_eff;
  logic [139:0] out_sel;
  logic [27:0]  out_on, out_eff;
  logic         sel_err;

  int n_cmp = 0, n_bad = 0;
  int m_dpd[5], m_dsel[5], m_dval[5];
  int m_opd[28], m_osel[28];
  bit m_err;

  always #2.5 clk = ~clk;

  clkgen_ctrl_regs u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_on(src_on),
    .div_sel(div_sel), .div_val(div_val), .div_on(div_on), .div_eff(div_eff),
    .out_sel(out_sel), .out_on(out_on), .out_eff(out_eff), .sel_err(sel_err)
  );

  task automatic chk(string tag, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int dw(int i);
    return (i == 0) ? 2 : (i == 4) ? 8 : 4;
  endfunction
  function automatic bit rsv(int j);
    return j >= 21 && j <= 24;
  endfunction
  function automatic bit d_legal(int i, int c);
    if (i == 0) return (c >= 0 && c <= 4) || (c >= 6 && c <= 9);
    return (c >= 0 && c <= 4) || c == 6 || c == 8 || c == 9 || c == 12;
  endfunction
  function automatic bit o_legal(int j, int c);
    if (j == 1) return c == 7;
    if (j == 3 || j == 20 || j == 26 || j == 27)
      return (c <= 4) || (c >= 6 && c <= 9) || (c >= 12 && c <= 16);
    return (c <= 4) || c == 6 || c == 8 || c == 9 || (c >= 12 && c <= 16);
  endfunction

  function automatic bit eff_a();
    return !m_dpd[0][0] && m_dsel[0] < 12 && src_on[m_dsel[0]];
  endfunction
  function automatic bit eff_d(int i);
    if (i == 0) return eff_a();
    if (m_dpd[i][0]) return 0;
    if (m_dsel[i] < 12) return src_on[m_dsel[i]];
    return m_dsel[i] == 12 && eff_a();
  endfunction
  function automatic bit eff_o(int j);
    if (j == 0) return src_on[1];
    if (rsv(j) || m_opd[j][0]) return 0;
    if (m_osel[j] < 12) return src_on[m_osel[j]];
    if (m_osel[j] <= 16) return eff_d(m_osel[j] - 12);
    return 0;
  endfunction

  function automatic int word_d(int i);
    return (m_dsel[i] << 24) | (m_dval[i] << 2) | m_dpd[i];
  endfunction
  function automatic int word_o(int j);
    if (j == 0) return 1 << 24;
    if (rsv(j)) return 0;
    return (m_osel[j] << 24) | m_opd[j];
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 5; i++) begin m_dpd[i] = 1; m_dsel[i] = 1; m_dval[i] = 0; end
    for (int j = 0; j < 28; j++) begin m_opd[j] = 1; m_osel[j] = (j == 1) ? 7 : 1; end
    m_err = 0;
  endtask

  task automatic model_write(int a, int w);
    int c = (w >> 24) & 31;
    for (int i = 0; i < 5; i++) if (a == 'h48 + 4*i) begin
      m_dpd[i] = w & 1;
      m_dval[i] = (w >> 2) & ((1 << dw(i)) - 1);
      if (d_legal(i, c)) m_dsel[i] = c; else m_err = 1;
    end
    for (int j = 1; j < 28; j++) if (a == 'h5C + 4*j && !rsv(j)) begin
      m_opd[j] = w & 1;
      if (o_legal(j, c)) m_osel[j] = c; else m_err = 1;
    end
  endtask

  task automatic do_wr(int a, int w);
    @(negedge clk);
    bus_wr = 1; bus_addr = 8'(a); bus_wdata = w;
    @(negedge clk);
    bus_wr = 0;
    model_write(a, w);
  endtask

  task automatic do_rd(int a, output int d);
    bus_rd = 1; bus_addr = 8'(a);
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic check_status(string tag);
    @(negedge clk);
    for (int i = 0; i < 5; i++) chk({tag, " R9 div_eff"}, div_eff[i], eff_d(i));
    for (int j = 0; j < 28; j++) chk({tag, " R9 out_eff"}, out_eff[j], eff_o(j));
    chk({tag, " R6 sel_err"}, sel_err, m_err);
  endtask

  task automatic full_check(string tag);
    int d;
    for (int i = 0; i < 5; i++) begin
      do_rd('h48 + 4*i, d);
      chk({tag, " R1 div word"}, d, word_d(i));
      chk({tag, " R1 div_sel port"}, div_sel[i*5 +: 5], m_dsel[i]);
      chk({tag, " R1 div_val port"}, div_val[i*8 +: 8], m_dval[i]);
      chk({tag, " R1 div_on port"}, div_on[i], !m_dpd[i][0]);
    end
    for (int j = 0; j < 28; j++) begin
      do_rd('h5C + 4*j, d);
      chk({tag, " R5 out word"}, d, word_o(j));
      chk({tag, " R8 out_sel port"}, out_sel[j*5 +: 5], rsv(j) ? 0 : (j == 0 ? 1 : m_osel[j]));
      chk({tag, " R7 out_on port"}, out_on[j], j == 0 ? 1 : (rsv(j) ? 0 : !m_opd[j][0]));
    end
    check_status(tag);
  endtask

  task automatic apply_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    model_reset();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int d, r, a, w, c;
    void'($urandom(32'h1D2C3B4A));
    apply_reset();
    // R10 reset values
    full_check("R10 reset");

    // R9 chain: divider B and output 2 fed through divider A
    src_on = 12'hFFF;
    do_wr('h48, (1 << 24) | 0);
    do_wr('h4C, (12 << 24) | (5 << 2));
    do_wr('h5C + 8, 13 << 24);
    full_check("R9 chain on");
    do_wr('h48, (1 << 24) | 1);
    full_check("R9 chain A off");
    src_on[1] = 0;
    check_status("R9 source off");

    // R7 safe output ignores writes
    do_wr('h5C, 32'h1F00_0001);
    full_check("R7 safe write");
    // R8 reserved slots
    do_wr('h5C + 4*22, 32'h0900_0000);
    do_rd('h5C + 4*22, d);
    chk("R8 reserved read", d, 0);
    do_rd('hFC, d);
    chk("R2 unmapped read", d, 0);
    check_status("R8 no error");

    // R3/R4 refused codes, R6 other fields still written
    do_wr('h48, (5 << 24) | (3 << 2));
    full_check("R3 code 5 on A");
    do_wr('h50, (7 << 24) | (9 << 2) | 1);
    full_check("R4 code 7 on C");
    // R5 USB output refuses code 8; R6 stays sticky after legal write
    do_wr('h60, (8 << 24));
    do_wr('h48, (6 << 24));
    full_check("R5 R6 sticky");

    // random phase
    apply_reset();
    for (int k = 0; k < 400; k++) begin
      r = $urandom_range(0, 9);
      if (r < 4)      a = 'h48 + 4 * $urandom_range(0, 4);
      else if (r < 9) a = 'h5C + 4 * $urandom_range(0, 27);
      else            a = 4 * $urandom_range(0, 63);
      c = ($urandom_range(0, 9) < 7) ? $urandom_range(0, 16) : $urandom_range(0, 31);
      w = ($urandom & 32'hE0FF_FFFF) | (c << 24);
      if ($urandom_range(0, 3) == 0) src_on = 12'($urandom);
      do_wr(a, w);
      do_rd(a, d);
      chk("R1 R5 random readback", d,
          (a >= 'h48 && a < 'h5C) ? word_d((a - 'h48) / 4) :
          (a >= 'h5C && a < 'h5C + 112) ? word_o((a - 'h5C) / 4) : 0);
      check_status("random");
      if (k % 50 == 49) full_check("random sweep");
      if (k == 200) apply_reset();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule